// File: doc/BRIEF.md
# Masked Pattern-Match Port Interrupt

This block watches an 8-bit input port and raises an interrupt when the port matches a programmed pattern over a chosen set of bits. Software writes a mask register and a pattern register. It also writes a control register that picks one of two trigger conditions: the masked bits are equal to the pattern, or the masked bits differ from it. A typical keypad setup sets the pattern to all ones and selects the "differs" condition. Any enabled key that pulls its line low then triggers.

The port is passed through a two-flop synchronizer before it is compared. A match counts only after it has held for more than six consecutive clock cycles. Once a match qualifies, a sticky flag is set. The flag stays set until software writes zero to it. When the interrupt enable is also set, the flag drives an interrupt request and an identical wake-up output, which a sleeping processor can use to resume.

Top module: `kpm_top`

## Requirements
- R1: After reset the mask, the pattern, the compare select, the interrupt enable, the flag, the interrupt and the wake-up output are all zero.
- R2: A write with `wr_en` high stores `wr_data` as follows: address 0 sets the mask and address 1 sets the pattern. Address 2 sets the control register, where bit 1 is the compare select (1 = differs) and bit 2 is the interrupt enable. The stored values appear on the readback ports after the write edge. Address 3 changes nothing.
- R3: Port bits whose mask bit is 0 have no effect on matching. With a mask of all zeros in equal mode, the port always counts as a match.
- R4: In equal mode (select 0), a match is present when the masked port bits equal the masked pattern bits.
- R5: In differs mode (select 1), a match is present when any masked port bit differs from the pattern. With the pattern at 0xFF, this fires when any masked port bit is low.
- R6: The flag sets only after a match has held for 7 consecutive synchronized cycles. If a port value is driven before rising edge k and then held, the flag is set at edge k+8. A match held for 6 cycles never sets the flag.
- R7: A single cycle without a match restarts the hold count from zero.
- R8: The flag is sticky. A write to address 2 with bit 0 equal to 0 clears it. A write to address 2 with bit 0 equal to 1 leaves it unchanged.
- R9: A clearing write also restarts the hold count. If the match persists, the flag sets again only after 7 more consecutive match cycles.
- R10: The interrupt output is high exactly when both the flag and the enable are set. The wake-up output always equals the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mask, 1 pattern, 2 control) |
| wr_data | input | 8 | Write data |
| port_in | input | 8 | Asynchronous port lines |
| mask_o | output | 8 | Mask register readback |
| pattern_o | output | 8 | Pattern register readback |
| match_sel_o | output | 1 | Compare select readback (1 = differs) |
| irq_en_o | output | 1 | Interrupt enable readback |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The assertions check the per-cycle rules on every cycle:
- the flag stays set until a clearing write, and a clearing write drops it;
- the flag rises only when the hold count has reached its last step;
- any non-matching cycle zeroes the count;
- a zero mask in equal mode always matches;
- the interrupt and wake-up outputs follow the gating rule.

Only the bench scenarios can show the following:
- the exact edge at which the flag appears after a port change, including the synchronizer delay;
- a six-cycle hold being rejected;
- a one-cycle gap restarting the count;
- the keypad-style differs setup reacting to one masked low line while an unmasked low line is ignored.

// File: rtl/kpm_pkg.sv
package kpm_pkg;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_PAT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_SEL_BIT  = 1;
  localparam int CTRL_EN_BIT   = 2;

  typedef enum logic {
    CMP_EQ = 1'b0,
    CMP_NE = 1'b1
  } cmp_mode_e;

  // Masked compare; operands are zero-extended to 32 bits (port width <= 32).
  function automatic logic masked_hit(input logic [31:0] port_v,
                                      input logic [31:0] mask_v,
                                      input logic [31:0] pat_v,
                                      input cmp_mode_e   mode);
    logic [31:0] diff;
    logic        any_diff;
    diff     = (port_v ^ pat_v) & mask_v;
    any_diff = |diff;
    return (mode == CMP_NE) ? any_diff : !any_diff;
  endfunction

endpackage

// File: rtl/kpm_sync.sv
module kpm_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/kpm_regs.sv
module kpm_regs
  import kpm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] pat_q,
  output cmp_mode_e        mode_q,
  output logic             en_q,
  output logic             clr_pulse
);

  logic wr_mask, wr_pat, wr_ctrl;

  assign wr_mask   = wr_en && (wr_addr == ADDR_MASK);
  assign wr_pat    = wr_en && (wr_addr == ADDR_PAT);
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_pulse = wr_ctrl && !wr_data[CTRL_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pat_q  <= '0;
      mode_q <= CMP_EQ;
      en_q   <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wr_data;
      if (wr_pat)  pat_q  <= wr_data;
      if (wr_ctrl) begin
        mode_q <= cmp_mode_e'(wr_data[CTRL_SEL_BIT]);
        en_q   <= wr_data[CTRL_EN_BIT];
      end
    end
  end

endmodule

// File: rtl/kpm_qual.sv
module kpm_qual #(
  parameter int HOLD = 7,
  localparam int CW  = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr,
  output logic          qual,
  output logic          flag_q,
  output logic [CW-1:0] run_cnt
);

  logic at_sat;

  assign at_sat = (run_cnt == CW'(HOLD));
  assign qual   = hit && (run_cnt == CW'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_cnt <= '0;
    else if (!hit || clr)  run_cnt <= '0;
    else if (!at_sat)      run_cnt <= run_cnt + 1'b1;
  end

  // a qualifying event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (qual) flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

endmodule

// File: rtl/kpm_top.sv
module kpm_top
  import kpm_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 7,
  localparam int CW         = $clog2(HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] pattern_o,
  output logic             match_sel_o,
  output logic             irq_en_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_o
);

  logic [WIDTH-1:0] port_sync;
  logic [WIDTH-1:0] mask_q, pat_q;
  cmp_mode_e        mode_q;
  logic             en_q;
  logic             clr_w;
  logic             hit_w;
  logic             qual_w;
  logic             flag_w;
  logic [CW-1:0]    run_cnt_w;

  kpm_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (port_in),
    .d_out (port_sync)
  );

  kpm_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mask_q    (mask_q),
    .pat_q     (pat_q),
    .mode_q    (mode_q),
    .en_q      (en_q),
    .clr_pulse (clr_w)
  );

  assign hit_w = masked_hit(32'(port_sync), 32'(mask_q), 32'(pat_q), mode_q);

  kpm_qual #(.HOLD(HOLD)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit_w),
    .clr     (clr_w),
    .qual    (qual_w),
    .flag_q  (flag_w),
    .run_cnt (run_cnt_w)
  );

  assign mask_o      = mask_q;
  assign pattern_o   = pat_q;
  assign match_sel_o = (mode_q == CMP_NE);
  assign irq_en_o    = en_q;
  assign flag_o      = flag_w;
  assign irq_o       = flag_w && en_q;
  assign wake_o      = irq_o;

endmodule

// File: rtl/kpm_chk.sv
module kpm_chk #(
  parameter int WIDTH = 8,
  parameter int HOLD  = 7,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] mask_o,
  input logic             match_sel_o,
  input logic             irq_en_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic             hit_w,
  input logic             qual_w,
  input logic [CW-1:0]    run_cnt_w
);

  logic clr_seen;
  assign clr_seen = wr_en && (wr_addr == 2'd2) && !wr_data[0];

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (mask_o == $past(wr_data)));

  // R3
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '0 && !match_sel_o) |-> hit_w);

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> ($past(hit_w) && $past(run_cnt_w) == CW'(HOLD - 1)));

  // R7
  run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_w |=> (run_cnt_w == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_seen) |=> flag_o);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_seen && !qual_w) |=> (!flag_o && run_cnt_w == '0));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (flag_o && irq_en_o));

  // R10
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o == irq_o);

endmodule

bind kpm_top kpm_chk #(.WIDTH(WIDTH), .HOLD(HOLD), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .mask_o      (mask_o),
  .match_sel_o (match_sel_o),
  .irq_en_o    (irq_en_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o),
  .hit_w       (hit_w),
  .qual_w      (qual_w),
  .run_cnt_w   (run_cnt_w)
);

// File: tb/kpm_top_bench.sv
module kpm_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] port_in = 8'd0;
  logic [7:0] mask_o, pattern_o;
  logic       match_sel_o, irq_en_o, flag_o, irq_o, wake_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  kpm_top u_kpm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_in(port_in), .mask_o(mask_o),
    .pattern_o(pattern_o), .match_sel_o(match_sel_o), .irq_en_o(irq_en_o),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  // ---------------- reference model built from the requirements ----------
  logic [7:0] m_p1, m_p2, m_mask, m_pat;
  logic       m_ne, m_en, m_flag;
  int         m_run;

  function automatic bit ref_match(logic [7:0] p, logic [7:0] m,
                                   logic [7:0] pt, logic ne);
    int nd = 0;
    for (int b = 0; b < 8; b++) if (m[b] && (p[b] != pt[b])) nd++;
    return ne ? (nd > 0) : (nd == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 <= 0; m_p2 <= 0; m_mask <= 0; m_pat <= 0;
      m_ne <= 0; m_en <= 0; m_flag <= 0; m_run <= 0;
    end else begin
      automatic bit h   = ref_match(m_p2, m_mask, m_pat, m_ne);
      automatic bit clr = wr_en && wr_addr == 2 && !wr_data[0];
      m_p1 <= port_in;
      m_p2 <= m_p1;
      if (!h || clr) m_run <= 0;
      else if (m_run < 7) m_run <= m_run + 1;
      if (h && m_run == 6) m_flag <= 1;
      else if (clr)        m_flag <= 0;
      if (wr_en && wr_addr == 0) m_mask <= wr_data;
      if (wr_en && wr_addr == 1) m_pat  <= wr_data;
      if (wr_en && wr_addr == 2) begin m_ne <= wr_data[1]; m_en <= wr_data[2]; end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(flag_o == m_flag, "R6 flag vs model", int'(flag_o), int'(m_flag));
      chk(irq_o == (m_flag && m_en), "R10 irq vs model", int'(irq_o), int'(m_flag && m_en));
      chk(wake_o == (m_flag && m_en), "R10 wake vs model", int'(wake_o), int'(m_flag && m_en));
      chk({mask_o, pattern_o, match_sel_o, irq_en_o} == {m_mask, m_pat, m_ne, m_en},
          "R2 registers vs model", int'({mask_o, pattern_o, match_sel_o, irq_en_o}),
          int'({m_mask, m_pat, m_ne, m_en}));
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait_n(200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1
    chk({mask_o, pattern_o, match_sel_o, irq_en_o, flag_o, irq_o, wake_o} == 0,
        "R1 reset state", int'({mask_o, pattern_o, match_sel_o, irq_en_o, flag_o, irq_o, wake_o}), 0);

    // R4 and R3: equal mode, upper bits unmasked and ignored
    wr(2'd0, 8'h0F); wr(2'd1, 8'h05); wr(2'd2, 8'h04);
    port_in = 8'h00; wait_n(12); wr(2'd2, 8'h04);
    chk(mask_o == 8'h0F && pattern_o == 8'h05 && irq_en_o && !match_sel_o,
        "R2 readback", int'({mask_o, pattern_o}), 32'h0F05);
    wr(2'd3, 8'hAA);
    chk(mask_o == 8'h0F && pattern_o == 8'h05, "R2 address 3 ignored",
        int'({mask_o, pattern_o}), 32'h0F05);
    port_in = 8'hA5;
    wait_n(8);
    chk(flag_o == 0, "R6 no flag at edge k+7", int'(flag_o), 0);
    wait_n(1);
    chk(flag_o == 1, "R6 flag at edge k+8", int'(flag_o), 1);
    chk(irq_o && wake_o, "R10 irq and wake with enable", int'({irq_o, wake_o}), 3);

    // R8: writing 1 to flag bit keeps it
    wr(2'd2, 8'h05);
    chk(flag_o == 1, "R8 write one keeps flag", int'(flag_o), 1);
    // R9: clear while match persists, refires after 7 cycles
    wr(2'd2, 8'h04);
    chk(flag_o == 0, "R8 clear by write zero", int'(flag_o), 0);
    wait_n(6);
    chk(flag_o == 0, "R9 no refire before fresh hold", int'(flag_o), 0);
    wait_n(1);
    chk(flag_o == 1, "R9 refire after fresh hold", int'(flag_o), 1);

    // R6: a 6-cycle hold is rejected
    port_in = 8'h00; wait_n(4); wr(2'd2, 8'h04);
    port_in = 8'h05; wait_n(6); port_in = 8'h00; wait_n(10);
    chk(flag_o == 0, "R6 six-cycle hold rejected", int'(flag_o), 0);
    // R7: one-cycle gap restarts the count
    port_in = 8'h05; wait_n(5); port_in = 8'h10; wait_n(1);
    port_in = 8'h05; wait_n(5); port_in = 8'h00; wait_n(10);
    chk(flag_o == 0, "R7 gap restarts count", int'(flag_o), 0);

    // R5: differs mode with pattern all ones
    wr(2'd0, 8'h3C); wr(2'd1, 8'hFF); port_in = 8'hFF; wait_n(4); wr(2'd2, 8'h06);
    wait_n(15);
    chk(flag_o == 0, "R5 all high no trigger", int'(flag_o), 0);
    port_in = 8'hFE; wait_n(15);
    chk(flag_o == 0, "R3 unmasked low line ignored", int'(flag_o), 0);
    port_in = 8'hF7; wait_n(9);
    chk(flag_o == 1 && irq_o, "R5 masked low line triggers", int'({flag_o, irq_o}), 3);

    // R3: zero mask in equal mode always matches; R10 gating
    wr(2'd0, 8'h00); port_in = 8'h5A; wr(2'd2, 8'h00);
    wait_n(8);
    chk(flag_o == 1, "R3 zero mask matches", int'(flag_o), 1);
    chk(!irq_o && !wake_o, "R10 no irq when disabled", int'({irq_o, wake_o}), 0);

    // random phase, checked each cycle against the model
    begin
      int left = 0;
      for (int i = 0; i < 4000; i++) begin
        if (left == 0) begin
          case ($urandom % 4)
            0: port_in = m_pat;
            1: port_in = m_pat ^ (8'd1 << ($urandom % 8));
            2: port_in = 8'($urandom);
            default: port_in = 8'hFF;
          endcase
          left = 1 + int'($urandom % 12);
        end
        left--;
        if ($urandom % 30 == 0) begin
          wr_en = 1; wr_addr = 2'($urandom); wr_data = 8'($urandom);
          if ($urandom % 2 == 0) wr_addr = 2'd2;
        end else begin
          wr_en = 0;
        end
        @(negedge clk);
      end
      wr_en = 0;
    end
    wait_n(2);
    finish_run();
  end

endmodule